// File: doc/BRIEF.md
# Host Mailbox Send Sequencer

This block sits on the host side of a shared-memory mailbox used to talk to an I/O coprocessor. The coprocessor offers seven outbound channels. Each channel has a single hardware slot of 32 bytes and a one-byte state cell. Because a slot holds only one message, the sequencer keeps a software-style queue per channel in front of it. The queued messages live in a small shared pool of payload entries.

A client hands over a message with a ready/valid request that carries a channel number, a length and up to 32 payload bytes. One cycle after the handshake the sequencer answers accept or reject. An accepted message joins the tail of its channel's queue. If the channel's state cell reads IDLE at that moment, the message is copied into the slot straight away, the state is set to NEW and the doorbell is pulsed.

When the coprocessor signals completion, the sequencer sweeps the state cells from channel 0 upwards. For each channel found COMPLETE, it sets the cell back to IDLE and streams the 32-byte reply out, tagged with the channel. It then releases the head entry and launches the next queued message on that channel, if one is waiting.

Top module: `mbx_send_seq`

## Requirements
- R1: A request whose channel is 7 or above, or whose length is above 32, is answered with rsp_ok=0, and nothing is queued or written to the mailbox.
- R2: With all 8 pool entries holding queued messages, any further request is answered with rsp_ok=0. Once a completion frees an entry, a request is accepted again.
- R3: After an accepted request, the sequencer reads state cell 224+chan. If it holds IDLE (0), the message is issued at once. Otherwise the message waits in the queue with no mailbox write and no doorbell.
- R4: Issuing a message writes slot bytes at addresses chan*32+i for i=0..31. Byte i is req_data[8i+7:8i] when i<len and 0 otherwise. The sequencer then writes NEW (1) to cell 224+chan, and in the next cycle it raises doorbell for one cycle.
- R5: A cpl_evt pulse starts a sweep of the cells of channels 0..6 in ascending order. Only cells holding COMPLETE (3) are acted on, so replies come out in ascending channel order. Cells in any other state (for example 2) are left unchanged.
- R6: For a COMPLETE channel with a queued message, the sequencer writes IDLE to its cell, reads the 32 slot bytes, and emits them on consecutive cycles with rpl_chan set and rpl_last on the 32nd byte. It then frees the head entry and issues the next queued message of that channel.
- R7: For a COMPLETE channel with an empty queue, the only action is writing IDLE to its cell. No reply is emitted.
- R8: Messages on one channel are issued in the order they were accepted.
- R9: req_ready is low while a mailbox transaction or sweep is in progress, or while a completion event is pending. rsp_valid pulses for one cycle, exactly one cycle after each handshake.
- R10: After reset, req_ready is high, and doorbell, rsp_valid, rpl_valid, mb_we and mb_re are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Send request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_chan | input | 3 | Target channel |
| req_len | input | 6 | Payload length in bytes |
| req_data | input | 256 | Payload, byte i in bits 8i+7:8i |
| rsp_valid | output | 1 | Accept/reject answer strobe |
| rsp_ok | output | 1 | 1 = accepted, 0 = rejected |
| cpl_evt | input | 1 | Completion event from the coprocessor |
| mb_we | output | 1 | Mailbox byte write strobe |
| mb_re | output | 1 | Mailbox byte read strobe (data returns the cycle after the mailbox samples it) |
| mb_addr | output | 8 | Mailbox byte address |
| mb_wdata | output | 8 | Mailbox write byte |
| mb_rdata | input | 8 | Mailbox read byte |
| doorbell | output | 1 | One-cycle interrupt to the coprocessor |
| rpl_valid | output | 1 | Reply byte strobe |
| rpl_chan | output | 3 | Channel of the reply |
| rpl_data | output | 8 | Reply byte |
| rpl_last | output | 1 | Last byte of a reply |

## Verification
The bench uses the default parameters: seven channels, 32-byte slots, eight pool entries and an 8-bit mailbox address. With only eight entries, the bench can exhaust the pool with a short burst of requests spread over four channels and then watch it recover after one completion sweep. A single completion event covering two channels is enough to show the ascending sweep order and the back-to-back launch of the next queued message. Short and zero lengths exercise the zero padding, and channel 7 and length 33 sit just outside the accepted range.

// File: rtl/mbx_send_pkg.sv
package mbx_send_pkg;
  localparam logic [7:0] CELL_IDLE = 8'd0;
  localparam logic [7:0] CELL_NEW  = 8'd1;
  localparam logic [7:0] CELL_DONE = 8'd3;

  typedef enum logic [3:0] {
    F_IDLE, F_ENQ_WAIT, F_ISS_LD, F_ISS_WR, F_ISS_NEW, F_ISS_BELL,
    F_SCAN_RD, F_SCAN_WAIT, F_CPL_IDLE, F_RPL_RD, F_RPL_DRAIN, F_POP, F_SCAN_NEXT
  } seq_state_e;
endpackage

// File: rtl/mbx_pool.sv
module mbx_pool #(
  parameter int ENTRIES = 8,
  parameter int DW = 256,
  parameter int LW = 6,
  localparam int PW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_en,
  input  logic [DW-1:0] wr_data,
  input  logic [LW-1:0] wr_len,
  output logic          has_free,
  output logic [PW-1:0] alloc_idx,
  input  logic          free_en,
  input  logic [PW-1:0] free_idx,
  input  logic [PW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] rd_len
);
  logic [ENTRIES-1:0] used;
  logic [DW-1:0] mem  [ENTRIES];
  logic [LW-1:0] lmem [ENTRIES];

  assign has_free = ~&used;

  always_comb begin
    alloc_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!used[i]) alloc_idx = PW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) used <= '0;
    else begin
      if (alloc_en) used[alloc_idx] <= 1'b1;
      if (free_en)  used[free_idx]  <= 1'b0;
    end
  end

  // payload store: no reset, registered read
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      mem[alloc_idx]  <= wr_data;
      lmem[alloc_idx] <= wr_len;
    end
    rd_data <= mem[rd_idx];
    rd_len  <= lmem[rd_idx];
  end
endmodule

// File: rtl/mbx_chain.sv
module mbx_chain #(
  parameter int NCH = 7,
  parameter int ENTRIES = 8,
  localparam int CHW = $clog2(NCH),
  localparam int PW = $clog2(ENTRIES),
  localparam int NSLOT = 2 ** CHW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CHW-1:0] sel_ch,
  input  logic           push_en,
  input  logic [PW-1:0]  push_ent,
  input  logic           pop_en,
  output logic           q_nonempty,
  output logic [PW-1:0]  q_head,
  output logic           q_more,
  output logic [PW-1:0]  q_next
);
  logic [PW-1:0] head_r [NSLOT];
  logic [PW-1:0] tail_r [NSLOT];
  logic [PW-1:0] nxt_r  [ENTRIES];
  logic [NSLOT-1:0] live;

  assign q_nonempty = live[sel_ch];
  assign q_head     = head_r[sel_ch];
  assign q_more     = live[sel_ch] && (head_r[sel_ch] != tail_r[sel_ch]);
  assign q_next     = nxt_r[head_r[sel_ch]];

  always_ff @(posedge clk) begin
    if (rst) live <= '0;
    else begin
      if (push_en) begin
        if (live[sel_ch]) nxt_r[tail_r[sel_ch]] <= push_ent;
        else begin
          head_r[sel_ch] <= push_ent;
          live[sel_ch]   <= 1'b1;
        end
        tail_r[sel_ch] <= push_ent;
      end
      if (pop_en) begin
        if (head_r[sel_ch] == tail_r[sel_ch]) live[sel_ch] <= 1'b0;
        else head_r[sel_ch] <= nxt_r[head_r[sel_ch]];
      end
    end
  end
endmodule

// File: rtl/mbx_send_seq.sv
module mbx_send_seq #(
  parameter int NCH = 7,
  parameter int MSG_BYTES = 32,
  parameter int POOL = 8,
  parameter int AW = 8,
  localparam int CHW = $clog2(NCH),
  localparam int LENW = $clog2(MSG_BYTES + 1),
  localparam int DW = MSG_BYTES * 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [CHW-1:0]  req_chan,
  input  logic [LENW-1:0] req_len,
  input  logic [DW-1:0]   req_data,
  output logic            rsp_valid,
  output logic            rsp_ok,
  input  logic            cpl_evt,
  output logic            mb_we,
  output logic            mb_re,
  output logic [AW-1:0]   mb_addr,
  output logic [7:0]      mb_wdata,
  input  logic [7:0]      mb_rdata,
  output logic            doorbell,
  output logic            rpl_valid,
  output logic [CHW-1:0]  rpl_chan,
  output logic [7:0]      rpl_data,
  output logic            rpl_last
);
  import mbx_send_pkg::*;

  localparam int PW = $clog2(POOL);
  localparam int IW = $clog2(MSG_BYTES);
  localparam int STATE_BASE = NCH * MSG_BYTES;

  seq_state_e st;
  logic [CHW-1:0] cur_ch;
  logic [PW-1:0]  cur_ent;
  logic [IW-1:0]  idx;
  logic scanning, int_pend;
  logic rt1, rk1, rl1, rt2, rk2, rl2;

  logic has_free, alloc_en, pop_en, req_good;
  logic [PW-1:0] alloc_idx, q_head, q_next;
  logic q_nonempty, q_more;
  logic [DW-1:0] pl_data;
  logic [LENW-1:0] pl_len;
  logic [CHW-1:0] sel_ch;
  logic [7:0] iss_byte;
  logic [AW-1:0] slot_addr, cell_addr;

  assign req_ready = (st == F_IDLE) && !int_pend;
  assign req_good  = (32'(req_chan) < NCH) && (32'(req_len) <= MSG_BYTES) && has_free;
  assign alloc_en  = req_ready && req_valid && req_good;
  assign pop_en    = (st == F_POP);
  assign sel_ch    = (st == F_IDLE) ? req_chan : cur_ch;
  assign slot_addr = AW'(cur_ch) * AW'(MSG_BYTES) + AW'(idx);
  assign cell_addr = AW'(STATE_BASE) + AW'(cur_ch);
  assign iss_byte  = (LENW'(idx) < pl_len) ? pl_data[idx*8 +: 8] : 8'h00;

  mbx_pool #(.ENTRIES(POOL), .DW(DW), .LW(LENW)) u_pool (
    .clk(clk), .rst(rst), .alloc_en(alloc_en), .wr_data(req_data), .wr_len(req_len),
    .has_free(has_free), .alloc_idx(alloc_idx), .free_en(pop_en), .free_idx(q_head),
    .rd_idx(cur_ent), .rd_data(pl_data), .rd_len(pl_len));

  mbx_chain #(.NCH(NCH), .ENTRIES(POOL)) u_chain (
    .clk(clk), .rst(rst), .sel_ch(sel_ch), .push_en(alloc_en), .push_ent(alloc_idx),
    .pop_en(pop_en), .q_nonempty(q_nonempty), .q_head(q_head), .q_more(q_more),
    .q_next(q_next));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= F_IDLE; cur_ch <= '0; cur_ent <= '0; idx <= '0;
      scanning <= 1'b0; int_pend <= 1'b0;
      mb_we <= 1'b0; mb_re <= 1'b0; mb_addr <= '0; mb_wdata <= '0;
      doorbell <= 1'b0; rsp_valid <= 1'b0; rsp_ok <= 1'b0;
      rt1 <= 1'b0; rk1 <= 1'b0; rl1 <= 1'b0; rt2 <= 1'b0; rk2 <= 1'b0; rl2 <= 1'b0;
      rpl_valid <= 1'b0; rpl_chan <= '0; rpl_data <= '0; rpl_last <= 1'b0;
    end else begin
      mb_we <= 1'b0; mb_re <= 1'b0; doorbell <= 1'b0; rsp_valid <= 1'b0;
      rt1 <= 1'b0; rk1 <= 1'b0; rl1 <= 1'b0;
      // read-return tracking: the mailbox answers one cycle after sampling
      rt2 <= rt1; rk2 <= rk1; rl2 <= rl1;
      rpl_valid <= rt2 & rk2;
      rpl_last  <= rt2 & rk2 & rl2;
      if (rt2 && rk2) begin
        rpl_data <= mb_rdata;
        rpl_chan <= cur_ch;
      end
      int_pend <= cpl_evt | (int_pend & (st != F_IDLE));
      case (st)
        F_IDLE: begin
          if (int_pend) begin
            scanning <= 1'b1; cur_ch <= '0; st <= F_SCAN_RD;
          end else if (req_valid) begin
            rsp_valid <= 1'b1;
            rsp_ok    <= req_good;
            if (req_good) begin
              cur_ch <= req_chan; cur_ent <= alloc_idx;
              mb_re <= 1'b1; mb_addr <= AW'(STATE_BASE) + AW'(req_chan);
              rt1 <= 1'b1; st <= F_ENQ_WAIT;
            end
          end
        end
        F_ENQ_WAIT: if (rt2) st <= (mb_rdata == CELL_IDLE) ? F_ISS_LD : F_IDLE;
        F_ISS_LD: begin idx <= '0; st <= F_ISS_WR; end
        F_ISS_WR: begin
          mb_we <= 1'b1; mb_addr <= slot_addr; mb_wdata <= iss_byte;
          idx <= idx + 1'b1;
          if (idx == IW'(MSG_BYTES - 1)) st <= F_ISS_NEW;
        end
        F_ISS_NEW: begin
          mb_we <= 1'b1; mb_addr <= cell_addr; mb_wdata <= CELL_NEW; st <= F_ISS_BELL;
        end
        F_ISS_BELL: begin
          doorbell <= 1'b1;
          st <= scanning ? F_SCAN_NEXT : F_IDLE;
        end
        F_SCAN_RD: begin
          mb_re <= 1'b1; mb_addr <= cell_addr; rt1 <= 1'b1; st <= F_SCAN_WAIT;
        end
        F_SCAN_WAIT: if (rt2) st <= (mb_rdata == CELL_DONE) ? F_CPL_IDLE : F_SCAN_NEXT;
        F_CPL_IDLE: begin
          mb_we <= 1'b1; mb_addr <= cell_addr; mb_wdata <= CELL_IDLE; idx <= '0;
          st <= q_nonempty ? F_RPL_RD : F_SCAN_NEXT;
        end
        F_RPL_RD: begin
          mb_re <= 1'b1; mb_addr <= slot_addr;
          rt1 <= 1'b1; rk1 <= 1'b1; rl1 <= (idx == IW'(MSG_BYTES - 1));
          idx <= idx + 1'b1;
          if (idx == IW'(MSG_BYTES - 1)) st <= F_RPL_DRAIN;
        end
        F_RPL_DRAIN: if (rt2 && rl2) st <= F_POP;
        F_POP: begin
          if (q_more) begin cur_ent <= q_next; st <= F_ISS_LD; end
          else st <= F_SCAN_NEXT;
        end
        F_SCAN_NEXT: begin
          if (32'(cur_ch) == NCH - 1) begin scanning <= 1'b0; st <= F_IDLE; end
          else begin cur_ch <= cur_ch + 1'b1; st <= F_SCAN_RD; end
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_send_chk.sv
module mbx_send_chk #(
  parameter int NCH = 7,
  parameter int MSG_BYTES = 32,
  parameter int POOL = 8,
  parameter int AW = 8,
  localparam int CHW = $clog2(NCH),
  localparam int LENW = $clog2(MSG_BYTES + 1),
  localparam int DW = MSG_BYTES * 8
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [CHW-1:0]  req_chan,
  input logic [LENW-1:0] req_len,
  input logic [DW-1:0]   req_data,
  input logic            rsp_valid,
  input logic            rsp_ok,
  input logic            cpl_evt,
  input logic            mb_we,
  input logic            mb_re,
  input logic [AW-1:0]   mb_addr,
  input logic [7:0]      mb_wdata,
  input logic [7:0]      mb_rdata,
  input logic            doorbell,
  input logic            rpl_valid,
  input logic [CHW-1:0]  rpl_chan,
  input logic [7:0]      rpl_data,
  input logic            rpl_last
);
  p_bell_after_new_r4: assert property (@(posedge clk) disable iff (rst)
    doorbell |-> ($past(mb_we) && $past(mb_wdata) == 8'd1 && 32'($past(mb_addr)) >= NCH * MSG_BYTES));

  p_port_excl_r4: assert property (@(posedge clk) disable iff (rst) !(mb_we && mb_re));

  p_reply_burst_r6: assert property (@(posedge clk) disable iff (rst)
    (rpl_valid && !rpl_last) |=> (rpl_valid && $stable(rpl_chan)));

  p_bad_chan_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && 32'(req_chan) >= NCH) |=> (rsp_valid && !rsp_ok));

  p_bad_len_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && 32'(req_len) > MSG_BYTES) |=> (rsp_valid && !rsp_ok));

  p_rsp_after_hs_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready));

  p_hs_gives_rsp_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);
endmodule

bind mbx_send_seq mbx_send_chk #(.NCH(NCH), .MSG_BYTES(MSG_BYTES), .POOL(POOL), .AW(AW)) u_chk (.*);

// File: tb/mbx_send_seq_tb.sv
module mbx_send_seq_tb;
  localparam int NCH = 7, MB = 32, POOL = 8, AW = 8, SB = NCH * MB;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready, rsp_valid, rsp_ok, cpl_evt = 1'b0;
  logic [2:0] req_chan = '0;
  logic [5:0] req_len = '0;
  logic [255:0] req_data = '0;
  logic mb_we, mb_re, doorbell, rpl_valid, rpl_last;
  logic [AW-1:0] mb_addr;
  logic [7:0] mb_wdata, mb_rdata, rpl_data;
  logic [2:0] rpl_chan;
  logic iop_we = 1'b0;
  logic [7:0] iop_addr = '0, iop_wdata = '0;
  logic [7:0] ram [256];

  always #10 clk = ~clk;

  mbx_send_seq u_dut (.*);

  // mailbox memory with one-cycle read latency
  always @(posedge clk) begin
    if (rst) for (int i = 0; i < 256; i++) ram[i] <= 8'h00;
    else if (mb_we) ram[mb_addr] <= mb_wdata;
    else if (iop_we) ram[iop_addr] <= iop_wdata;
    if (mb_re) mb_rdata <= ram[mb_addr];
  end

  int vec = 0, bad = 0, cyc = 0, serial = 0, round = 0, ridx = 0, last_new = 0;
  logic [255:0] mdat [NCH][POOL+1];
  int mlen [NCH][POOL+1];
  int mcnt [NCH];
  bit issued [NCH];
  logic [7:0] rbuf [NCH][MB];
  int rexp [$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(input int ch, input int k);
    for (int b = 0; b < MB; b++) mk[8*b +: 8] = 8'(ch * 29 + k * 13 + b * 7 + 1);
  endfunction

  task automatic pop_model(input int ch);
    for (int k = 0; k < POOL; k++) begin
      mdat[ch][k] = mdat[ch][k+1];
      mlen[ch][k] = mlen[ch][k+1];
    end
    mcnt[ch]--;
    issued[ch] = 0;
  endtask

  // one clock: advance to the falling edge and compare against the model
  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL R9 watchdog: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
    if (doorbell) begin
      int ch, mism;
      ch = last_new;
      check(mcnt[ch] > 0 && !issued[ch], "R3 doorbell only for a waiting head", issued[ch], 0);
      if (mcnt[ch] > 0) begin
        mism = 0;
        for (int b = 0; b < MB; b++) begin
          logic [7:0] e;
          e = (b < mlen[ch][0]) ? mdat[ch][0][8*b +: 8] : 8'h00;
          if (ram[ch*MB + b] != e) mism++;
        end
        check(mism == 0, "R4 R8 slot bytes of head message", mism, 0);
      end
      check(ram[SB+ch] == 8'd1, "R4 state cell NEW at doorbell", ram[SB+ch], 1);
      issued[ch] = 1;
    end
    if (rpl_valid) begin
      if (rexp.size() == 0) check(0, "R7 unexpected reply byte", rpl_chan, 0);
      else begin
        int ch;
        ch = rexp[0];
        check(rpl_chan == 3'(ch), "R5 reply channel order", rpl_chan, ch);
        check(rpl_data == rbuf[ch][ridx], "R6 reply byte", rpl_data, rbuf[ch][ridx]);
        check(rpl_last == (ridx == MB - 1), "R6 reply last flag", rpl_last, ridx == MB - 1);
        ridx++;
        if (rpl_last || ridx == MB) begin
          ridx = 0;
          void'(rexp.pop_front());
          pop_model(ch);
        end
      end
    end
    if (mb_we && 32'(mb_addr) >= SB && mb_wdata == 8'd1) last_new = 32'(mb_addr) - SB;
  endtask

  task automatic wait_idle();
    repeat (3) tick();
    while (!req_ready) tick();
  endtask

  task automatic iop_write(input int a, input logic [7:0] d);
    iop_we = 1'b1; iop_addr = 8'(a); iop_wdata = d;
    tick();
    iop_we = 1'b0;
  endtask

  task automatic send(input int ch, input int len, input bit exp_ok);
    logic [255:0] d;
    bit pre_idle;
    serial++;
    d = mk(ch, serial);
    req_valid = 1'b1; req_chan = 3'(ch); req_len = 6'(len); req_data = d;
    while (!req_ready) tick();
    pre_idle = (ch < NCH) && (ram[SB+ch] == 8'd0);
    tick();
    req_valid = 1'b0;
    check(rsp_valid && rsp_ok == exp_ok, "R1 R2 R9 accept answer", {rsp_valid, rsp_ok}, {1'b1, exp_ok});
    if (exp_ok && rsp_ok) begin
      mdat[ch][mcnt[ch]] = d;
      mlen[ch][mcnt[ch]] = len;
      mcnt[ch]++;
    end
    wait_idle();
    if (exp_ok && pre_idle) check(issued[ch], "R3 immediate issue on idle cell", issued[ch], 1);
  endtask

  task automatic complete(input logic [6:0] mask);
    round++;
    for (int ch = 0; ch < NCH; ch++) if (mask[ch]) begin
      for (int b = 0; b < MB; b++) begin
        rbuf[ch][b] = 8'(ch * 17 + b * 3 + round * 41);
        iop_write(ch*MB + b, rbuf[ch][b]);
      end
      iop_write(SB + ch, 8'd3);
      if (mcnt[ch] > 0) rexp.push_back(ch);
    end
    cpl_evt = 1'b1;
    tick();
    cpl_evt = 1'b0;
    wait_idle();
    check(rexp.size() == 0, "R5 every COMPLETE channel handled", rexp.size(), 0);
    for (int ch = 0; ch < NCH; ch++) if (mask[ch])
      check(ram[SB+ch] == (issued[ch] ? 8'd1 : 8'd0), "R6 R7 cell after completion",
            ram[SB+ch], issued[ch] ? 1 : 0);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin mcnt[c] = 0; issued[c] = 0; end
    repeat (4) tick();
    check(req_ready == 1'b1, "R10 ready in reset", req_ready, 1);
    check(!doorbell && !rsp_valid && !rpl_valid && !mb_we && !mb_re, "R10 outputs quiet",
          {doorbell, rsp_valid, rpl_valid, mb_we, mb_re}, 0);
    rst = 1'b0;
    tick();
    check(req_ready == 1'b1 && !mb_we, "R10 ready after reset", req_ready, 1);

    send(2, 5, 1);          // R3 R4: issued, bytes 5..31 zero
    send(2, 32, 1);         // queued behind NEW cell
    send(2, 17, 1);
    send(5, 0, 1);          // R4: all-zero slot
    send(5, 32, 1);
    send(7, 4, 0);          // R1 channel out of range
    send(1, 33, 0);         // R1 length too large
    send(0, 8, 1);
    send(0, 9, 1);
    send(3, 31, 1);         // pool now full (8 entries)
    send(4, 3, 0);          // R2 pool exhausted
    complete(7'b0100100);   // channels 2 and 5 in one event, R5 order
    send(4, 3, 1);          // R2 entry recovered
    complete(7'b0000010);   // R7 empty queue on channel 1

    iop_write(SB + 0, 8'd2);  // channel 0 cell in state 2
    cpl_evt = 1'b1; tick(); cpl_evt = 1'b0;
    wait_idle();
    check(ram[SB] == 8'd2, "R5 non-complete cell untouched", ram[SB], 2);
    check(issued[0] && mcnt[0] == 2, "R5 no action on state 2", mcnt[0], 2);

    for (int r = 0; r < 16; r++) begin
      logic [6:0] m;
      m = '0;
      for (int c = 0; c < NCH; c++) if (issued[c]) m[c] = 1'b1;
      if (m == '0) break;
      complete(m);
    end
    for (int c = 0; c < NCH; c++) check(mcnt[c] == 0, "R8 queue drained in order", mcnt[c], 0);

    for (int k = 0; k < POOL; k++) send(6, k * 4, 1);   // R2 whole pool free again
    send(6, 1, 0);
    for (int r = 0; r < 10; r++) if (issued[6]) complete(7'b1000000);
    check(mcnt[6] == 0, "R8 channel 6 FIFO drained", mcnt[6], 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule